// File: doc/BRIEF.md
# Cartridge DMA Register Front-End

This block is the memory-mapped control port of a cartridge-to-DRAM DMA engine. Software programs a DRAM address and a cartridge address, then writes a length word to launch a transfer. Each direction has its own length register. The block merges every write under per-byte enables. It clips each address register to its legal bits when the value is stored, and it emits a one-cycle launch strobe to the data mover. While a transfer runs, the block reports busy. When the mover signals completion, it raises an interrupt flag.

The length registers never echo the value that was written. Once a transfer has been accepted, a length register reads a fixed idle value of 0x7F. There is one exception: when a cartridge-to-DRAM transfer of eight bytes or fewer is accepted, that register reads 0x7F minus the low three bits of the DRAM address in effect at launch. The data mover itself lies outside this block. It receives the launch strobes, the merged length field and the two address registers, and it returns a completion pulse.

Top module: `cdma_regs`

## Requirements
- R1: After reset, the DRAM and cartridge address registers read 0, both length registers read 0x7F, and the status word reads 0.
- R2: A write replaces only the bytes whose enable bit is 1 and keeps the other bytes of the stored value. This applies to the address registers and to the length field.
- R3: A write to the DRAM address register (select 0) stores the merged value ANDed with 0x00FFFFFE.
- R4: A write to the cartridge address register (select 1) stores the merged value ANDed with 0xFFFFFFFE.
- R5: A write to the write-length register (select 3) while not busy has these effects in the next cycle: `wr_start_o` is high for exactly one cycle, busy is set, and `xfer_len_o` holds the merged low 24 bits.
- R6: After an accepted write-length launch, that register reads 0x7F when the field plus one exceeds 8. Otherwise it reads 0x7F minus (DRAM address & 7).
- R7: A write to the read-length register (select 2) while not busy has these effects: a one-cycle `rd_start_o`, busy set, the merged field on `xfer_len_o`, and a readback of 0x7F.
- R8: A `done_i` pulse clears busy and sets the interrupt flag. The status word (select 4) has bit 0 = busy and bit 3 = interrupt.
- R9: A status write that has byte 0 enabled and data bit 1 set clears the interrupt flag. A `done_i` in the same cycle wins, and the flag stays set.
- R10: Writes to either length register while busy are ignored: no strobe, and no change to `xfer_len_o` or to the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Word select of the register being accessed |
| wdata | input | 32 | Write data |
| wbe | input | 4 | Byte enables for the write |
| rdata | output | 32 | Readback of the selected register (combinational) |
| done_i | input | 1 | Completion pulse from the data mover |
| wr_start_o | output | 1 | One-cycle cartridge-to-DRAM launch strobe |
| rd_start_o | output | 1 | One-cycle DRAM-to-cartridge launch strobe |
| xfer_len_o | output | 24 | Length field captured at the last launch |
| dram_addr_o | output | 32 | Stored DRAM address |
| cart_addr_o | output | 32 | Stored cartridge address |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Completion interrupt flag |

## Verification
Launches are tried with short lengths at two DRAM misalignments (2 and 6), with a length field of exactly 7 against 8, and with long lengths. Together these separate the short-transfer adjustment from the plain idle value and place the boundary correctly. Byte-masked writes, including a launch with every enable at 0, show whether merging uses the old stored word. Launch attempts while busy, and an interrupt clear that coincides with completion, expose wrong gating and wrong priority in the status logic.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
   // word selects of the register map
   localparam int unsigned SEL_DRAM  = 0;
   localparam int unsigned SEL_CART  = 1;
   localparam int unsigned SEL_RDLEN = 2;
   localparam int unsigned SEL_WRLEN = 3;
   localparam int unsigned SEL_STAT  = 4;
   // status word bit positions
   localparam int unsigned STB_BUSY  = 0;
   localparam int unsigned STB_CLR   = 1;
   localparam int unsigned STB_IRQ   = 3;
endpackage

// File: rtl/cdma_bytemerge.sv
module cdma_bytemerge #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0]   old_i,
   input  logic [W-1:0]   new_i,
   input  logic [W/8-1:0] be_i,
   output logic [W-1:0]   out_o
);
   localparam int unsigned NB = W / 8;

   if (W % 8 != 0 || W == 0) begin : g_bad_width
      $error("cdma_bytemerge: W must be a non-zero multiple of 8");
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign out_o[b*8 +: 8] = be_i[b] ? new_i[b*8 +: 8] : old_i[b*8 +: 8];
   end
endmodule

// File: rtl/cdma_lenfix.sv
module cdma_lenfix #(
   parameter int unsigned   W         = 32,
   parameter int unsigned   LEN_W     = 24,
   parameter logic [W-1:0]  IDLE_VAL  = 'h7F,
   parameter int unsigned   SHORT_MAX = 8,
   parameter bit            SHORT_ADJ = 1'b1
) (
   input  logic [LEN_W-1:0] field_i,
   input  logic [2:0]       misalign_i,
   output logic [W-1:0]     val_o
);
   if (SHORT_MAX == 0 || SHORT_MAX > 8) begin : g_bad_short
      $error("cdma_lenfix: SHORT_MAX must lie in 1..8");
   end

   if (SHORT_ADJ) begin : g_adjust
      // field + 1 <= SHORT_MAX  <=>  field < SHORT_MAX
      logic is_short;
      assign is_short = ({1'b0, field_i} < (LEN_W+1)'(SHORT_MAX));
      assign val_o    = is_short ? (IDLE_VAL - W'(misalign_i)) : IDLE_VAL;
   end else begin : g_plain
      assign val_o = IDLE_VAL;
   end
endmodule

// File: rtl/cdma_status.sv
module cdma_status (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_go_i,
   input  logic rd_go_i,
   input  logic done_i,
   input  logic clr_i,
   output logic busy_o,
   output logic irq_o,
   output logic wr_pulse_o,
   output logic rd_pulse_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o     <= 1'b0;
         irq_o      <= 1'b0;
         wr_pulse_o <= 1'b0;
         rd_pulse_o <= 1'b0;
      end else begin
         wr_pulse_o <= wr_go_i;
         rd_pulse_o <= rd_go_i;
         if (wr_go_i || rd_go_i)
            busy_o <= 1'b1;
         else if (done_i)
            busy_o <= 1'b0;
         if (done_i)
            irq_o <= 1'b1;
         else if (clr_i)
            irq_o <= 1'b0;
      end
   end
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs #(
   parameter int unsigned        DATA_W    = 32,
   parameter int unsigned        SEL_W     = 3,
   parameter int unsigned        LEN_W     = 24,
   parameter logic [DATA_W-1:0]  DRAM_MASK = 'h00FF_FFFE,
   parameter logic [DATA_W-1:0]  CART_MASK = 'hFFFF_FFFE,
   parameter logic [DATA_W-1:0]  IDLE_LEN  = 'h7F,
   parameter int unsigned        SHORT_MAX = 8,
   parameter bit                 SHORT_ADJ = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    reg_sel,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] wbe,
   output logic [DATA_W-1:0]   rdata,
   input  logic                done_i,
   output logic                wr_start_o,
   output logic                rd_start_o,
   output logic [LEN_W-1:0]    xfer_len_o,
   output logic [DATA_W-1:0]   dram_addr_o,
   output logic [DATA_W-1:0]   cart_addr_o,
   output logic                busy_o,
   output logic                irq_o
);
   import cdma_pkg::*;

   localparam int unsigned NB   = DATA_W / 8;
   localparam int unsigned LNB  = LEN_W / 8;

   if (DATA_W % 8 != 0 || DATA_W <= cdma_pkg::STB_IRQ) begin : g_bad_data
      $error("cdma_regs: DATA_W must be a multiple of 8 and hold the status bits");
   end
   if (LEN_W % 8 != 0 || LEN_W > DATA_W || LEN_W == 0) begin : g_bad_len
      $error("cdma_regs: LEN_W must be a non-zero multiple of 8 and fit in DATA_W");
   end
   if (SEL_W < 3) begin : g_bad_sel
      $error("cdma_regs: SEL_W must cover five registers");
   end

   logic [DATA_W-1:0] dram_q, cart_q, rdlen_q, wrlen_q;
   logic [LEN_W-1:0]  xlen_q;

   logic hit_dram, hit_cart, hit_rdlen, hit_wrlen, hit_stat;
   assign hit_dram  = wr_en && (reg_sel == SEL_W'(SEL_DRAM));
   assign hit_cart  = wr_en && (reg_sel == SEL_W'(SEL_CART));
   assign hit_rdlen = wr_en && (reg_sel == SEL_W'(SEL_RDLEN));
   assign hit_wrlen = wr_en && (reg_sel == SEL_W'(SEL_WRLEN));
   assign hit_stat  = wr_en && (reg_sel == SEL_W'(SEL_STAT));

   // shared merge for the two address registers
   logic [DATA_W-1:0] addr_old, addr_new;
   assign addr_old = (reg_sel == SEL_W'(SEL_CART)) ? cart_q : dram_q;

   cdma_bytemerge #(.W(DATA_W)) u_addr_merge (
      .old_i (addr_old),
      .new_i (wdata),
      .be_i  (wbe),
      .out_o (addr_new)
   );

   // shared merge for the two length fields
   logic [LEN_W-1:0] len_old, len_new;
   assign len_old = (reg_sel == SEL_W'(SEL_RDLEN)) ? rdlen_q[LEN_W-1:0]
                                                   : wrlen_q[LEN_W-1:0];

   cdma_bytemerge #(.W(LEN_W)) u_len_merge (
      .old_i (len_old),
      .new_i (wdata[LEN_W-1:0]),
      .be_i  (wbe[LNB-1:0]),
      .out_o (len_new)
   );

   logic [DATA_W-1:0] wr_fix;
   cdma_lenfix #(
      .W         (DATA_W),
      .LEN_W     (LEN_W),
      .IDLE_VAL  (IDLE_LEN),
      .SHORT_MAX (SHORT_MAX),
      .SHORT_ADJ (SHORT_ADJ)
   ) u_lenfix (
      .field_i    (len_new),
      .misalign_i (dram_q[2:0]),
      .val_o      (wr_fix)
   );

   logic wr_go, rd_go, clr_irq;
   assign wr_go   = hit_wrlen && !busy_o;
   assign rd_go   = hit_rdlen && !busy_o;
   assign clr_irq = hit_stat && wbe[STB_CLR/8] && wdata[STB_CLR];

   cdma_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_go_i    (wr_go),
      .rd_go_i    (rd_go),
      .done_i     (done_i),
      .clr_i      (clr_irq),
      .busy_o     (busy_o),
      .irq_o      (irq_o),
      .wr_pulse_o (wr_start_o),
      .rd_pulse_o (rd_start_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dram_q  <= '0;
         cart_q  <= '0;
         rdlen_q <= IDLE_LEN;
         wrlen_q <= IDLE_LEN;
         xlen_q  <= '0;
      end else begin
         if (hit_dram) dram_q <= addr_new & DRAM_MASK;
         if (hit_cart) cart_q <= addr_new & CART_MASK;
         if (rd_go) begin
            rdlen_q <= IDLE_LEN;
            xlen_q  <= len_new;
         end
         if (wr_go) begin
            wrlen_q <= wr_fix;
            xlen_q  <= len_new;
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (reg_sel)
         SEL_W'(SEL_DRAM):  rdata = dram_q;
         SEL_W'(SEL_CART):  rdata = cart_q;
         SEL_W'(SEL_RDLEN): rdata = rdlen_q;
         SEL_W'(SEL_WRLEN): rdata = wrlen_q;
         SEL_W'(SEL_STAT): begin
            rdata[STB_BUSY] = busy_o;
            rdata[STB_IRQ]  = irq_o;
         end
         default:           rdata = '0;
      endcase
   end

   assign xfer_len_o  = xlen_q;
   assign dram_addr_o = dram_q;
   assign cart_addr_o = cart_q;
endmodule

// File: rtl/cdma_regs_chk.sv
module cdma_regs_chk #(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       SEL_W     = 3,
   parameter logic [DATA_W-1:0] DRAM_MASK = 'h00FF_FFFE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [SEL_W-1:0]  reg_sel,
   input logic              clr_bit,
   input logic              clr_be,
   input logic              done_i,
   input logic              wr_start_o,
   input logic              rd_start_o,
   input logic              busy_o,
   input logic              irq_o,
   input logic [DATA_W-1:0] dram_addr_o
);
   // R5
   wr_pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> busy_o);

   // R5
   wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |=> !wr_start_o);

   // R7
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start_o |-> (busy_o && !wr_start_o));

   // R3
   dram_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_addr_o & ~DRAM_MASK) == '0);

   // R8
   done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> irq_o);

   // R9
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == SEL_W'(cdma_pkg::SEL_STAT) && clr_be && clr_bit && !done_i)
         |=> !irq_o);

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && wr_en && (reg_sel == SEL_W'(cdma_pkg::SEL_WRLEN) ||
                           reg_sel == SEL_W'(cdma_pkg::SEL_RDLEN)))
         |=> (!wr_start_o && !rd_start_o));
endmodule

bind cdma_regs cdma_regs_chk #(
   .DATA_W    (DATA_W),
   .SEL_W     (SEL_W),
   .DRAM_MASK (DRAM_MASK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .reg_sel     (reg_sel),
   .clr_bit     (wdata[cdma_pkg::STB_CLR]),
   .clr_be      (wbe[0]),
   .done_i      (done_i),
   .wr_start_o  (wr_start_o),
   .rd_start_o  (rd_start_o),
   .busy_o      (busy_o),
   .irq_o       (irq_o),
   .dram_addr_o (dram_addr_o)
);

// File: tb/sim_cdma_regs.sv
`timescale 1ns/1ps
module sim_cdma_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [3:0]  wbe = 4'd0;
   logic        done_i = 1'b0;
   logic [31:0] rdata;
   logic        wr_start_o, rd_start_o, busy_o, irq_o;
   logic [23:0] xfer_len_o;
   logic [31:0] dram_addr_o, cart_addr_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cdma_regs u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
      .wdata(wdata), .wbe(wbe), .rdata(rdata), .done_i(done_i),
      .wr_start_o(wr_start_o), .rd_start_o(rd_start_o),
      .xfer_len_o(xfer_len_o), .dram_addr_o(dram_addr_o),
      .cart_addr_o(cart_addr_o), .busy_o(busy_o), .irq_o(irq_o)
   );

   // behavioural reference state
   logic [31:0] m_dram, m_cart, m_rdlen, m_wrlen;
   logic [23:0] m_xlen;
   logic        m_busy, m_irq, m_wrs, m_rds;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] bemask(input logic [3:0] be);
      logic [31:0] m = 32'd0;
      for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
      return m;
   endfunction

   function automatic logic [31:0] m_read(input logic [2:0] s);
      case (s)
         3'd0: return m_dram;
         3'd1: return m_cart;
         3'd2: return m_rdlen;
         3'd3: return m_wrlen;
         3'd4: return {28'd0, m_irq, 2'b00, m_busy};
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_reset();
      m_dram = 0; m_cart = 0; m_rdlen = 32'h7F; m_wrlen = 32'h7F;
      m_xlen = 0; m_busy = 0; m_irq = 0; m_wrs = 0; m_rds = 0;
   endtask

   task automatic model_step();
      logic [31:0] mk, merged;
      logic go_w, go_r, clr;
      integer f;
      mk   = bemask(wbe);
      go_w = wr_en && reg_sel == 3'd3 && !m_busy;
      go_r = wr_en && reg_sel == 3'd2 && !m_busy;
      clr  = wr_en && reg_sel == 3'd4 && wbe[0] && wdata[1];
      if (go_w) begin
         merged = (m_wrlen & ~mk) | (wdata & mk);
         f = merged & 32'h00FF_FFFF;
         m_xlen = merged[23:0];
         m_wrlen = (f + 1 <= 8) ? 32'h7F - (m_dram & 32'h7) : 32'h7F;
      end
      if (go_r) begin
         merged = (m_rdlen & ~mk) | (wdata & mk);
         m_xlen = merged[23:0];
         m_rdlen = 32'h7F;
      end
      if (wr_en && reg_sel == 3'd0) m_dram = ((m_dram & ~mk) | (wdata & mk)) & 32'h00FF_FFFE;
      if (wr_en && reg_sel == 3'd1) m_cart = ((m_cart & ~mk) | (wdata & mk)) & 32'hFFFF_FFFE;
      if (go_w || go_r) m_busy = 1; else if (done_i) m_busy = 0;
      if (done_i) m_irq = 1; else if (clr) m_irq = 0;
      m_wrs = go_w; m_rds = go_r;
   endtask

   task automatic compare_all();
      chk("R3 dram_addr", dram_addr_o, m_dram);
      chk("R4 cart_addr", cart_addr_o, m_cart);
      chk("R5 wr_start", {31'd0, wr_start_o}, {31'd0, m_wrs});
      chk("R7 rd_start", {31'd0, rd_start_o}, {31'd0, m_rds});
      chk("R5 xfer_len", {8'd0, xfer_len_o}, {8'd0, m_xlen});
      chk("R8 busy", {31'd0, busy_o}, {31'd0, m_busy});
      chk("R8 irq", {31'd0, irq_o}, {31'd0, m_irq});
      chk("R6 rdata", rdata, m_read(reg_sel));
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      wr_en = 0; done_i = 0; wbe = 0; wdata = 0;
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d, input logic [3:0] be);
      reg_sel = s; wdata = d; wbe = be; wr_en = 1;
      cycle();
      idle();
   endtask

   task automatic pulse_done();
      done_i = 1;
      cycle();
      idle();
   endtask

   task automatic rdchk(input logic [2:0] s, input logic [31:0] exp, input string tag);
      wr_en = 0; reg_sel = s;
      #1;
      chk(tag, rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset values
      rdchk(3'd0, 32'h0, "R1 dram");
      rdchk(3'd1, 32'h0, "R1 cart");
      rdchk(3'd2, 32'h7F, "R1 rdlen");
      rdchk(3'd3, 32'h7F, "R1 wrlen");
      rdchk(3'd4, 32'h0, "R1 status");
      cycle();

      wr(3'd0, 32'h1234_5679, 4'hF);
      rdchk(3'd0, 32'h0034_5678, "R3 dram mask");
      wr(3'd1, 32'hFFFF_FFFF, 4'hF);
      rdchk(3'd1, 32'hFFFF_FFFE, "R4 cart mask");
      wr(3'd0, 32'hAAAA_AAAA, 4'b0010);
      rdchk(3'd0, 32'h0034_AA78, "R2 byte merge");

      // short launch, misalignment 2
      wr(3'd0, 32'h0000_1003, 4'hF);
      wr(3'd3, 32'h0000_0003, 4'hF);
      chk("R5 pulse", {31'd0, wr_start_o}, 32'd1);
      chk("R5 busy", {31'd0, busy_o}, 32'd1);
      chk("R5 len", {8'd0, xfer_len_o}, 32'd3);
      rdchk(3'd3, 32'h7D, "R6 short mis2");
      cycle();
      chk("R5 single pulse", {31'd0, wr_start_o}, 32'd0);

      // launches while busy
      wr(3'd3, 32'h0000_0100, 4'hF);
      chk("R10 no pulse", {31'd0, wr_start_o}, 32'd0);
      chk("R10 len kept", {8'd0, xfer_len_o}, 32'd3);
      rdchk(3'd3, 32'h7D, "R10 wrlen kept");
      wr(3'd2, 32'h0000_0005, 4'hF);
      chk("R10 no rd pulse", {31'd0, rd_start_o}, 32'd0);

      pulse_done();
      chk("R8 busy clear", {31'd0, busy_o}, 32'd0);
      rdchk(3'd4, 32'h8, "R8 status word");
      wr(3'd4, 32'h0000_0002, 4'b0000);
      rdchk(3'd4, 32'h8, "R9 no clear without enable");
      wr(3'd4, 32'h0000_0002, 4'b0001);
      chk("R9 cleared", {31'd0, irq_o}, 32'd0);

      // boundary: length 8, misalignment 6
      wr(3'd0, 32'h0000_1006, 4'hF);
      wr(3'd3, 32'h0000_0007, 4'hF);
      rdchk(3'd3, 32'h79, "R6 len 8");
      pulse_done();
      // length 9
      wr(3'd3, 32'h0000_0008, 4'hF);
      rdchk(3'd3, 32'h7F, "R6 len 9");
      pulse_done();
      // long launch
      wr(3'd3, 32'h0000_1000, 4'hF);
      rdchk(3'd3, 32'h7F, "R6 long");

      // completion together with clear: completion wins
      reg_sel = 3'd4; wdata = 32'h2; wbe = 4'h1; wr_en = 1; done_i = 1;
      cycle();
      idle();
      chk("R9 done wins", {31'd0, irq_o}, 32'd1);

      // read-direction launch
      wr(3'd2, 32'h0000_0020, 4'hF);
      chk("R7 rd pulse", {31'd0, rd_start_o}, 32'd1);
      chk("R7 len", {8'd0, xfer_len_o}, 32'h20);
      rdchk(3'd2, 32'h7F, "R7 rdlen");
      pulse_done();

      // launch with all enables off: field is old stored word
      wr(3'd3, 32'h0000_0001, 4'b0000);
      chk("R2 len merge", {8'd0, xfer_len_o}, 32'h7F);
      pulse_done();
      repeat (3) cycle();

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule